// File: doc/BRIEF.md
# Status Register and Write-Protect Arbiter

This block keeps the protection state of a serial nonvolatile memory and decides, cycle by cycle, whether a write to the data array or to the status register may go ahead. It holds three nonvolatile protection bits: a pin-enable bit and a two-bit block-protect level. It also holds the volatile write-enable latch, and it reports the busy state that an external write-cycle sequencer feeds in. A front-end that decodes serial commands drives the latch strobes, the status-write strobe with its data byte, the end-of-frame strobe (the chip select being released) and the latched page start address. The block answers with two permit lines, a commit pulse that starts the internal write cycle for a status write, and the byte returned by a status read.

The write-protect pin only takes effect when the pin-enable bit is one. When the pin is low and the bit is set, status writes are refused, so the bit cannot be cleared while the pin stays low. Array writes into unprotected regions are still allowed in that state. A status write is captured during the frame and applied only when the frame ends. If the pin drops while the frame is still open, the captured write is discarded. Once a write cycle has started, the pin no longer changes anything.

Top module: `wprot_status`

## Requirements
- R1: After reset the status byte reads 00h, and both permit outputs and the commit pulse are low.
- R2: A set-latch strobe makes status bit 1 (write enable) read one on the next cycle. A clear-latch strobe makes it read zero. When both strobes arrive in the same cycle, the clear wins. The wp_high_i pin has no influence on either strobe.
- R3: While busy_i is low, the status byte reads bit 7 = pin-enable, bits 3:2 = block-protect level, bit 1 = write enable, and bits 6:4 and bit 0 = zero.
- R4: While busy_i is high, the status byte reads FFh.
- R5: arr_wr_ok_o is high only when the latch is set, busy_i is low and arr_addr_i lies outside the protected range. With the default 17-bit address the ranges are: level 00 protects nothing; level 01 protects 18000h-1FFFFh; level 10 protects 10000h-1FFFFh; level 11 protects every address.
- R6: sr_wr_ok_o is high only when the latch is set, busy_i is low and hardware protection is off. Hardware protection is on when wp_high_i is low and the pin-enable bit is one. The pin never changes arr_wr_ok_o.
- R7: A status-write strobe captures sr_data_i. On the next frame_end_i, if sr_wr_ok_o is high, sr_commit_o pulses in that cycle and only bits 7, 3 and 2 are taken from the captured byte. The other status bits are not changed by the write.
- R8: If hardware protection turns on while a status write is captured and the frame is still open, the write is dropped. It is not applied even if the pin returns high before frame_end_i.
- R9: While busy_i is high, the set-latch, clear-latch and status-write strobes are ignored.
- R10: When busy_i falls (end of a write cycle), the write-enable latch clears.
- R11: A protection value that has been committed is kept when wp_high_i changes during or after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_high_i | input | 1 | Write-protect pin level (1 = not protecting) |
| set_wel_i | input | 1 | Set write-enable latch strobe |
| clr_wel_i | input | 1 | Clear write-enable latch strobe |
| sr_wr_stb_i | input | 1 | Capture a status-write byte |
| sr_data_i | input | 8 | Status-write data byte |
| frame_end_i | input | 1 | Frame closes (select released) |
| arr_addr_i | input | ADDR_W | Latched page start address of an array write |
| busy_i | input | 1 | Internal write cycle running |
| status_o | output | 8 | Status byte for reads |
| arr_wr_ok_o | output | 1 | Array write permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |
| sr_commit_o | output | 1 | Status write accepted; start write cycle |

## Verification
The array permit is tried over a table of addresses that sit just below and just above each range boundary, for all four protection levels. This separates a decoder that is off by one at a boundary from one that checks the wrong half of the array. The status permit is tried with every combination of pin level and pin-enable. The combination of pin low with the enable clear shows whether the pin is wrongly acting on its own, and the same state with an array write shows whether the pin leaks into array protection. Directed sequences cover the following cases: both latch strobes in one cycle, a pin pulse while a status write is pending, strobes issued while busy, and the latch clearing at the end of a cycle. These tell apart designs that sample protection at the wrong moment.

// File: rtl/wprot_status_pkg.sv
package wprot_status_pkg;
  localparam int SR_W     = 8;
  localparam int B_PINEN  = 7;
  localparam int B_LVL1   = 3;
  localparam int B_LVL0   = 2;
  localparam int B_WEN    = 1;
  localparam int B_BUSY   = 0;
  localparam logic [SR_W-1:0] NV_MASK =
    (SR_W'(1) << B_PINEN) | (SR_W'(1) << B_LVL1) | (SR_W'(1) << B_LVL0);

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_QTR  = 2'b01,
    LVL_HALF = 2'b10,
    LVL_ALL  = 2'b11
  } prot_lvl_e;
endpackage

// File: rtl/wprot_range_dec.sv
module wprot_range_dec
  import wprot_status_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

  always_comb begin
    case (prot_lvl_e'(lvl_i))
      LVL_NONE: hit_o = 1'b0;
      LVL_QTR:  hit_o = (addr_i >= QTR_BASE);
      LVL_HALF: hit_o = (addr_i >= HALF_BASE);
      default:  hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  input  logic cyc_done_i,
  output logic wen_o
);
  logic wen_d, wen_q;

  always_comb begin
    wen_d = wen_q;
    if (cyc_done_i)   wen_d = 1'b0;
    else if (!busy_i) begin
      if (clr_i)      wen_d = 1'b0;
      else if (set_i) wen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wen_q <= 1'b0;
    else        wen_q <= wen_d;
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/wprot_nv_store.sv
module wprot_nv_store
  import wprot_status_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic [SR_W-1:0] data_i,
  input  logic            busy_i,
  input  logic            hw_lock_i,
  input  logic            frame_end_i,
  input  logic            ok_i,
  output logic [SR_W-1:0] nv_o,
  output logic            commit_o
);
  logic            pend_d, pend_q;
  logic [SR_W-1:0] hold_d, hold_q;
  logic [SR_W-1:0] nv_d, nv_q;

  assign commit_o = frame_end_i & pend_q & ok_i;

  always_comb begin
    pend_d = pend_q;
    hold_d = hold_q;
    nv_d   = nv_q;
    if (pend_q && hw_lock_i) pend_d = 1'b0;
    if (stb_i && !busy_i) begin
      pend_d = 1'b1;
      hold_d = data_i;
    end
    if (frame_end_i) pend_d = 1'b0;
    if (commit_o) nv_d = (nv_q & ~NV_MASK) | (hold_q & NV_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      nv_q   <= '0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
      nv_q   <= nv_d;
    end
  end

  assign nv_o = nv_q & NV_MASK;
endmodule

// File: rtl/wprot_status.sv
module wprot_status
  import wprot_status_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_high_i,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              sr_wr_stb_i,
  input  logic [7:0]        sr_data_i,
  input  logic              frame_end_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              busy_i,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o,
  output logic              sr_commit_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            busy_q;
  logic            wen_q;
  logic            hw_lock;
  logic            range_hit;
  logic [SR_W-1:0] nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) busy_q <= 1'b0;
    else            busy_q <= busy_i;
  end

  wprot_wel u_wel (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_i      (set_wel_i),
    .clr_i      (clr_wel_i),
    .busy_i     (busy_i),
    .cyc_done_i (busy_q & ~busy_i),
    .wen_o      (wen_q)
  );

  assign hw_lock    = nv[B_PINEN] & ~wp_high_i;
  assign sr_wr_ok_o = wen_q & ~hw_lock & ~busy_i;

  wprot_nv_store u_nv (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .stb_i       (sr_wr_stb_i),
    .data_i      (sr_data_i),
    .busy_i      (busy_i),
    .hw_lock_i   (hw_lock),
    .frame_end_i (frame_end_i),
    .ok_i        (sr_wr_ok_o),
    .nv_o        (nv),
    .commit_o    (sr_commit_o)
  );

  wprot_range_dec #(.ADDR_W(ADDR_W)) u_dec (
    .lvl_i  ({nv[B_LVL1], nv[B_LVL0]}),
    .addr_i (arr_addr_i),
    .hit_o  (range_hit)
  );

  assign arr_wr_ok_o = wen_q & ~range_hit & ~busy_i;

  always_comb begin
    if (busy_i) status_o = '1;
    else begin
      status_o        = nv;
      status_o[B_WEN] = wen_q;
    end
  end
endmodule

// File: rtl/wprot_status_chk.sv
module wprot_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_high_i,
  input logic       busy_i,
  input logic [7:0] status_o,
  input logic       arr_wr_ok_o,
  input logic       sr_wr_ok_o,
  input logic       sr_commit_o,
  input logic       wen_q
);
  // R4
  a_r4_busy_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (status_o == 8'hFF));
  // R3
  a_r3_idle_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));
  // R6
  a_r6_pin_blocks_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[7] && !wp_high_i) |-> !sr_wr_ok_o);
  // R5
  a_r5_all_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);
  // R2
  a_r2_latch_needed: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |-> (!arr_wr_ok_o && !sr_wr_ok_o && !sr_commit_o));
  // R9
  a_r9_no_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !wen_q) |=> !wen_q);
  // R10
  a_r10_cycle_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |=> !wen_q);
  // R8
  a_r8_commit_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit_o |-> (wp_high_i || !status_o[7]));
endmodule

bind wprot_status wprot_status_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wp_high_i   (wp_high_i),
  .busy_i      (busy_i),
  .status_o    (status_o),
  .arr_wr_ok_o (arr_wr_ok_o),
  .sr_wr_ok_o  (sr_wr_ok_o),
  .sr_commit_o (sr_commit_o),
  .wen_q       (wen_q)
);

// File: tb/wprot_status_tb_top.sv
`timescale 1ns/1ps
module wprot_status_tb_top;
  localparam int ADDR_W = 17;
  localparam int NVEC   = 12;
  // {level[1:0], address[16:0], expected permit}
  localparam logic [19:0] VEC [NVEC] = '{
    {2'b00, 17'h00000, 1'b1}, {2'b00, 17'h1FFFF, 1'b1},
    {2'b01, 17'h17FFF, 1'b1}, {2'b01, 17'h18000, 1'b0},
    {2'b01, 17'h1FFFF, 1'b0}, {2'b01, 17'h00000, 1'b1},
    {2'b10, 17'h0FFFF, 1'b1}, {2'b10, 17'h10000, 1'b0},
    {2'b10, 17'h18000, 1'b0}, {2'b11, 17'h00000, 1'b0},
    {2'b11, 17'h0FFFF, 1'b0}, {2'b11, 17'h1FFFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, wp_high, set_wel, clr_wel, sr_stb, frame_end, busy;
  logic [7:0] sr_data;
  logic [ADDR_W-1:0] addr;
  logic [7:0] status;
  logic arr_ok, sr_ok, commit;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wprot_status #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_high_i(wp_high), .set_wel_i(set_wel),
    .clr_wel_i(clr_wel), .sr_wr_stb_i(sr_stb), .sr_data_i(sr_data),
    .frame_end_i(frame_end), .arr_addr_i(addr), .busy_i(busy),
    .status_o(status), .arr_wr_ok_o(arr_ok), .sr_wr_ok_o(sr_ok),
    .sr_commit_o(commit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // latch on, capture byte, close frame, run a short write cycle
  task automatic program_sr(input logic [7:0] d);
    set_wel = 1; step(); set_wel = 0;
    sr_stb = 1; sr_data = d; step(); sr_stb = 0;
    frame_end = 1; #1 check("R7 commit pulse", commit, 1); step(); frame_end = 0;
    busy = 1; #1 check("R4 busy reads FF", status, 8'hFF);
    step(); step(); step(); busy = 0; step(); step();
  endtask

  initial begin
    rst_n = 0; wp_high = 1; set_wel = 0; clr_wel = 0; sr_stb = 0;
    sr_data = 0; frame_end = 0; busy = 0; addr = '0;
    step(); step(); rst_n = 1; step(); step(); step();

    // R1 reset state
    #1 check("R1 status", status, 8'h00);
    check("R1 arr_ok", arr_ok, 0);
    check("R1 sr_ok", sr_ok, 0);
    check("R1 commit", commit, 0);

    // R2 latch strobes, pin low does not matter
    wp_high = 0; set_wel = 1; step(); set_wel = 0;
    #1 check("R2 set latch", status, 8'h02);
    clr_wel = 1; set_wel = 1; step(); clr_wel = 0; set_wel = 0;
    #1 check("R2 clear wins", status, 8'h00);
    wp_high = 1;

    // R5 table walk
    begin
      logic [1:0] cur = 2'b00;
      for (int i = 0; i < NVEC; i++) begin
        if (VEC[i][19:18] != cur) begin
          cur = VEC[i][19:18];
          program_sr({4'b0, cur, 2'b0});
        end
        set_wel = 1; step(); set_wel = 0;
        addr = VEC[i][17:1];
        #1 check("R5 range permit", arr_ok, VEC[i][0]);
      end
    end
    addr = '0;

    // R5 latch required, R10 latch cleared at cycle end
    program_sr(8'h00);
    #1 check("R10 latch cleared after cycle", status[1], 0);
    check("R5 no latch no permit", arr_ok, 0);

    // R7 only bits 7,3,2 taken; R3 layout
    program_sr(8'hFF);
    #1 check("R7 R3 masked write", status, 8'h8C);

    // R6 pin only when enabled
    program_sr(8'h80);
    wp_high = 0; set_wel = 1; step(); set_wel = 0;
    #1 check("R6 pin locks status write", sr_ok, 0);
    addr = 17'h1FFFF;
    check("R6 array unaffected by pin", arr_ok, 1);
    wp_high = 1; #1 check("R6 pin high unlocks", sr_ok, 1);

    // R8 abort on pin pulse during frame
    sr_stb = 1; sr_data = 8'h00; step(); sr_stb = 0;
    wp_high = 0; step(); wp_high = 1;
    frame_end = 1; #1 check("R8 aborted no commit", commit, 0);
    step(); frame_end = 0;
    #1 check("R8 value kept", status, 8'h82);

    // R6 enable stuck while pin low
    wp_high = 0; sr_stb = 1; sr_data = 8'h00; step(); sr_stb = 0;
    frame_end = 1; #1 check("R6 stuck commit", commit, 0); step(); frame_end = 0;
    #1 check("R6 stuck value", status[7], 1);
    wp_high = 1;

    // R6 enable clear: pin low has no effect
    program_sr(8'h00);
    wp_high = 0; set_wel = 1; step(); set_wel = 0;
    #1 check("R6 pin ignored when disabled", sr_ok, 1);
    wp_high = 1; clr_wel = 1; step(); clr_wel = 0;

    // R9 strobes ignored while busy
    busy = 1; sr_stb = 1; sr_data = 8'h8C; set_wel = 1; step();
    sr_stb = 0; set_wel = 0; step(); busy = 0; step(); step();
    #1 check("R9 set ignored while busy", status[1], 0);
    set_wel = 1; step(); set_wel = 0;
    frame_end = 1; #1 check("R9 capture ignored while busy", commit, 0);
    step(); frame_end = 0;
    #1 check("R9 status unchanged", status, 8'h02);

    // R11 committed value survives pin changes
    set_wel = 1; step(); set_wel = 0;
    sr_stb = 1; sr_data = 8'h84; step(); sr_stb = 0;
    frame_end = 1; #1 check("R11 commit", commit, 1); step(); frame_end = 0;
    busy = 1; wp_high = 0; step(); step(); busy = 0; step(); step();
    #1 check("R11 value after pin low", status, 8'h84);
    wp_high = 1; step();
    #1 check("R11 value after pin high", status, 8'h84);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule